// File: doc/BRIEF.md
# Interlaced 4:2:2 Embedded-Sync Video Word Generator

This block emits a continuous byte-wide stream of multiplexed 4:2:2 component video for a 525-line interlaced raster, one word per clock, for a downstream video encoder that runs as a timing slave. The encoder has no separate sync pins. Every line carries two four-word timing codes that stand in for data words. The end-of-active code opens the line and the start-of-active code comes just before the picture. Their last byte carries the field flag, the vertical-blanking flag and the horizontal flag, plus protection bits. All other non-picture words are filled with neutral blanking values.

On lines with active picture, the block pulls pixel words from a line buffer. The request/data pair works as a ready/valid handshake in which the generator owns the timing. `pix_req` (ready) is high in the cycle the source must accept as a request. The source answers in the following cycle with `pix_data` qualified by `pix_valid`. The output cannot stall, so there is no back-pressure toward the video side. A word that is not valid when it is due is replaced by the blanking value for its position. `pix_valid` has no effect in any cycle that does not follow a request. Two strobes mark the first word of each line and the first word of each field, and they are aligned with `vid_data`.

The default parameters give 858 luma periods per line, 720 of them active, and 525 lines with 487 active. All line boundaries are parameters.

Top module: `vid422_stream_gen`

## Requirements
- R1: Word positions within a line are counted from 0 at the first end-of-active code word. Each line lasts 2*LINE_SAMPLES words in this order: end-of-active code at positions 0..3, blanking, start-of-active code in the last 4 words before the active region, then 2*ACTIVE_SAMPLES active-region words. The stream advances one word per clock.
- R2: Each timing code is the byte sequence 0xFF, 0x00, 0x00, XY. In XY, bit 7 is 1, bit 6 is F, bit 5 is V, bit 4 is H, bit 3 is V^H, bit 2 is F^H, bit 1 is F^V and bit 0 is F^V^H. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R3: Lines are numbered from 1. F is 0 on lines F0_FIRST to F1_FIRST-1 and 1 on all other lines. V is 1 on lines below VACT1_FIRST and on lines VBLK2_FIRST to VACT2_FIRST-1, and 0 on all other lines. Both codes of a line use that line's flags.
- R4: Every blanking word is 0x80 at an even position and 0x10 at an odd position. This applies to the horizontal blanking and to the whole active region of lines with V=1.
- R5: `pix_req` is high exactly two cycles before `vid_data` shows an active-region word of a line with V=1 cleared. It is low at every other time.
- R6: `pix_data` is taken when `pix_valid` is high in the cycle after a request, and it appears on `vid_data` one cycle later. If `pix_valid` is low in that cycle, the blanking value from R4 is sent instead. `pix_valid` outside that cycle has no effect.
- R7: `line_start` is high exactly while `vid_data` shows position 0 of a line. `field_start` is high exactly while `vid_data` shows position 0 of line F0_FIRST or of line F1_FIRST.
- R8: While `rst_n` is low, `vid_data` is 0x80 and `pix_req`, `line_start` and `field_start` are low. On the second rising edge after release, `vid_data` shows position 0 of line 1.
- R9: After line FRAME_LINES, the line number returns to 1 and the pattern repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_req | output | 1 | Pixel request (ready), two cycles ahead of the active word |
| pix_data | input | 8 | Pixel word from the line buffer |
| pix_valid | input | 1 | Qualifies pix_data in the cycle after a request |
| vid_data | output | 8 | Multiplexed video word stream |
| line_start | output | 1 | High on the first code word of each line |
| field_start | output | 1 | High on the first code word of each field |

## Verification
The bench compares every output word against a model of the raster. It uses a shortened raster so that several frames and both field changes are covered. The pixel source supplies random data and drops `pix_valid` at random, and it also raises `pix_valid` when no request was made. A design that is off by one in the request lookahead would shift every pixel by one word. A design that ignored the valid qualifier, or accepted unrequested data, would put stray bytes into the blanking. Wrong flag boundaries or protection bits show up as bad XY bytes on the lines around the field and vertical-blanking changes. A missed line wrap shows up as a bad code after the last line. A reset applied in the middle of a line checks the idle outputs and a clean restart at line 1.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

  typedef enum logic [2:0] {
    K_SYNC_FF = 3'd0,
    K_SYNC_Z1 = 3'd1,
    K_SYNC_Z2 = 3'd2,
    K_SYNC_XY = 3'd3,
    K_BLANK   = 3'd4,
    K_ACTIVE  = 3'd5
  } word_kind_e;

  localparam logic [7:0] BLANK_CHROMA = 8'h80;
  localparam logic [7:0] BLANK_LUMA   = 8'h10;

  function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
    logic [3:0] prot;
    prot[3] = v ^ h;
    prot[2] = f ^ h;
    prot[1] = f ^ v;
    prot[0] = f ^ v ^ h;
    return {1'b1, f, v, h, prot};
  endfunction

endpackage

// File: rtl/vid422_timing.sv
module vid422_timing #(
  parameter int ACTIVE_SAMPLES = 720,
  parameter int LINE_SAMPLES   = 858,
  parameter int FRAME_LINES    = 525,
  parameter int F0_FIRST       = 4,
  parameter int F1_FIRST       = 266,
  parameter int VACT1_FIRST    = 20,
  parameter int VBLK2_FIRST    = 264,
  parameter int VACT2_FIRST    = 283,
  localparam int LINE_WORDS    = 2 * LINE_SAMPLES,
  localparam int WORD_W        = $clog2(LINE_WORDS),
  localparam int LINE_W        = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] word_cnt,
  output logic [LINE_W-1:0] line_num,
  output logic              fld,
  output logic              vblk,
  output logic              line_first,
  output logic              field_first
);

  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES);
  localparam logic [LINE_W-1:0] ONE_LINE  = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_F0      = LINE_W'(F0_FIRST);
  localparam logic [LINE_W-1:0] L_F1      = LINE_W'(F1_FIRST);
  localparam logic [LINE_W-1:0] L_VA1     = LINE_W'(VACT1_FIRST);
  localparam logic [LINE_W-1:0] L_VB2     = LINE_W'(VBLK2_FIRST);
  localparam logic [LINE_W-1:0] L_VA2     = LINE_W'(VACT2_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cnt <= '0;
      line_num <= ONE_LINE;
    end else if (word_cnt == LAST_WORD) begin
      word_cnt <= '0;
      line_num <= (line_num == LAST_LINE) ? ONE_LINE : line_num + ONE_LINE;
    end else begin
      word_cnt <= word_cnt + WORD_W'(1);
    end
  end

  always_comb begin
    fld         = !((line_num >= L_F0) && (line_num < L_F1));
    vblk        = (line_num < L_VA1) || ((line_num >= L_VB2) && (line_num < L_VA2));
    line_first  = (word_cnt == '0);
    field_first = line_first && ((line_num == L_F0) || (line_num == L_F1));
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt != LAST_WORD) |=> $stable(line_num)); // R1
  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt == LAST_WORD) |=> (word_cnt == '0)); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt == LAST_WORD && line_num == LAST_LINE) |=> (line_num == ONE_LINE)); // R9
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num >= ONE_LINE) && (line_num <= LAST_LINE)); // R9

endmodule

// File: rtl/vid422_code_gen.sv
module vid422_code_gen
  import vid422_pkg::*;
#(
  parameter int ACTIVE_SAMPLES = 720,
  parameter int LINE_SAMPLES   = 858,
  localparam int LINE_WORDS    = 2 * LINE_SAMPLES,
  localparam int ACT_WORDS     = 2 * ACTIVE_SAMPLES,
  localparam int HBLK_WORDS    = LINE_WORDS - ACT_WORDS,
  localparam int WORD_W        = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_cnt,
  input  logic              fld,
  input  logic              vblk,
  input  logic              line_first,
  input  logic              field_first,
  output logic              pix_req,
  output word_kind_e        s1_kind,
  output logic [7:0]        s1_byte,
  output logic              s1_req,
  output logic              s1_ls,
  output logic              s1_fs
);

  localparam logic [WORD_W-1:0] EAV_END = WORD_W'(4);
  localparam logic [WORD_W-1:0] SAV_AT  = WORD_W'(HBLK_WORDS - 4);
  localparam logic [WORD_W-1:0] ACT_AT  = WORD_W'(HBLK_WORDS);

  word_kind_e kind;
  logic [7:0] cur_byte;
  logic [7:0] blank_byte;
  logic       in_eav;
  logic       in_sav;

  always_comb begin
    blank_byte = word_cnt[0] ? BLANK_LUMA : BLANK_CHROMA;
    in_eav     = (word_cnt < EAV_END);
    in_sav     = (word_cnt >= SAV_AT) && (word_cnt < ACT_AT);
    kind       = K_BLANK;
    cur_byte   = blank_byte;
    if (in_eav || in_sav) begin
      case (word_cnt[1:0])
        2'd0: begin kind = K_SYNC_FF; cur_byte = 8'hFF; end
        2'd1: begin kind = K_SYNC_Z1; cur_byte = 8'h00; end
        2'd2: begin kind = K_SYNC_Z2; cur_byte = 8'h00; end
        default: begin kind = K_SYNC_XY; cur_byte = status_byte(fld, vblk, in_eav); end
      endcase
    end else if (word_cnt >= ACT_AT) begin
      kind = K_ACTIVE;
    end
    pix_req = (kind == K_ACTIVE) && !vblk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kind <= K_BLANK;
      s1_byte <= BLANK_CHROMA;
      s1_req  <= 1'b0;
      s1_ls   <= 1'b0;
      s1_fs   <= 1'b0;
    end else begin
      s1_kind <= kind;
      s1_byte <= cur_byte;
      s1_req  <= pix_req;
      s1_ls   <= line_first;
      s1_fs   <= field_first;
    end
  end

  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_SYNC_FF) |=> (s1_kind == K_SYNC_Z1)); // R2
  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> (s1_kind == K_ACTIVE && s1_req)); // R5
  AST_LS_AT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    s1_ls |-> (s1_kind == K_SYNC_FF)); // R7

endmodule

// File: rtl/vid422_out_mux.sv
module vid422_out_mux
  import vid422_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  word_kind_e s1_kind,
  input  logic [7:0] s1_byte,
  input  logic       s1_req,
  input  logic       s1_ls,
  input  logic       s1_fs,
  input  logic [7:0] pix_data,
  input  logic       pix_valid,
  output logic [7:0] vid_data,
  output logic       line_start,
  output logic       field_start
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_data    <= BLANK_CHROMA;
      line_start  <= 1'b0;
      field_start <= 1'b0;
    end else begin
      vid_data    <= (s1_req && pix_valid) ? pix_data : s1_byte;
      line_start  <= s1_ls;
      field_start <= s1_fs;
    end
  end

  AST_LS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (vid_data == 8'hFF)); // R7
  AST_FS_LS: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> line_start); // R7
  AST_XY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_SYNC_XY) |=> vid_data[7]); // R2
  AST_NO_UNREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_req && s1_kind == K_ACTIVE) |=> (vid_data == 8'h80 || vid_data == 8'h10)); // R6

endmodule

// File: rtl/vid422_stream_gen.sv
module vid422_stream_gen
  import vid422_pkg::*;
#(
  parameter int ACTIVE_SAMPLES = 720,
  parameter int LINE_SAMPLES   = 858,
  parameter int FRAME_LINES    = 525,
  parameter int F0_FIRST       = 4,
  parameter int F1_FIRST       = 266,
  parameter int VACT1_FIRST    = 20,
  parameter int VBLK2_FIRST    = 264,
  parameter int VACT2_FIRST    = 283
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       pix_req,
  input  logic [7:0] pix_data,
  input  logic       pix_valid,
  output logic [7:0] vid_data,
  output logic       line_start,
  output logic       field_start
);

  localparam int WORD_W = $clog2(2 * LINE_SAMPLES);
  localparam int LINE_W = $clog2(FRAME_LINES + 1);

  logic [WORD_W-1:0] word_cnt;
  logic [LINE_W-1:0] line_num;
  logic              fld, vblk, line_first, field_first;
  word_kind_e        s1_kind;
  logic [7:0]        s1_byte;
  logic              s1_req, s1_ls, s1_fs;

  vid422_timing #(
    .ACTIVE_SAMPLES(ACTIVE_SAMPLES), .LINE_SAMPLES(LINE_SAMPLES),
    .FRAME_LINES(FRAME_LINES), .F0_FIRST(F0_FIRST), .F1_FIRST(F1_FIRST),
    .VACT1_FIRST(VACT1_FIRST), .VBLK2_FIRST(VBLK2_FIRST), .VACT2_FIRST(VACT2_FIRST)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .word_cnt(word_cnt), .line_num(line_num),
    .fld(fld), .vblk(vblk), .line_first(line_first), .field_first(field_first)
  );

  vid422_code_gen #(
    .ACTIVE_SAMPLES(ACTIVE_SAMPLES), .LINE_SAMPLES(LINE_SAMPLES)
  ) u_code (
    .clk(clk), .rst_n(rst_n), .word_cnt(word_cnt), .fld(fld), .vblk(vblk),
    .line_first(line_first), .field_first(field_first), .pix_req(pix_req),
    .s1_kind(s1_kind), .s1_byte(s1_byte), .s1_req(s1_req),
    .s1_ls(s1_ls), .s1_fs(s1_fs)
  );

  vid422_out_mux u_mux (
    .clk(clk), .rst_n(rst_n), .s1_kind(s1_kind), .s1_byte(s1_byte),
    .s1_req(s1_req), .s1_ls(s1_ls), .s1_fs(s1_fs), .pix_data(pix_data),
    .pix_valid(pix_valid), .vid_data(vid_data), .line_start(line_start),
    .field_start(field_start)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!pix_req && !line_start && !field_start)); // R8
  AST_REQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && line_start) |-> 1'b0); // R5

endmodule

// File: tb/vid422_stream_gen_bench.sv
module vid422_stream_gen_bench;

  localparam int ACT  = 4;
  localparam int LS   = 10;
  localparam int NL   = 12;
  localparam int F0   = 2;
  localparam int F1   = 8;
  localparam int VA1  = 3;
  localparam int VB2  = 7;
  localparam int VA2  = 9;
  localparam int LW   = 2 * LS;
  localparam int HB   = 2 * (LS - ACT);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_req;
  logic [7:0] pix_data = 8'h00;
  logic       pix_valid = 1'b0;
  logic [7:0] vid_data;
  logic       line_start, field_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vid422_stream_gen #(
    .ACTIVE_SAMPLES(ACT), .LINE_SAMPLES(LS), .FRAME_LINES(NL),
    .F0_FIRST(F0), .F1_FIRST(F1), .VACT1_FIRST(VA1),
    .VBLK2_FIRST(VB2), .VACT2_FIRST(VA2)
  ) u_vid422_stream_gen (
    .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .pix_data(pix_data),
    .pix_valid(pix_valid), .vid_data(vid_data), .line_start(line_start),
    .field_start(field_start)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic bit f_of(input int l);
    return !(l >= F0 && l < F1);
  endfunction

  function automatic bit v_of(input int l);
    return (l < VA1) || (l >= VB2 && l < VA2);
  endfunction

  function automatic logic [7:0] xy_of(input bit f, input bit v, input bit h);
    logic [7:0] b;
    b = 8'h80;
    if (f) b = b | 8'h40 | 8'h04 | 8'h02 | 8'h01;
    if (v) b = b ^ 8'h20 ^ 8'h08 ^ 8'h02 ^ 8'h01;
    if (h) b = b ^ 8'h10 ^ 8'h08 ^ 8'h04 ^ 8'h01;
    return b;
  endfunction

  function automatic logic [7:0] blank_of(input int w);
    return (w % 2 == 0) ? 8'h80 : 8'h10;
  endfunction

  // R8: idle outputs during reset
  task automatic check_reset_state();
    chk(vid_data == 8'h80, "R8 vid_data in reset", vid_data, 8'h80);
    chk(!pix_req && !line_start && !field_start, "R8 strobes in reset",
        {5'd0, pix_req, line_start, field_start}, 8'h00);
  endtask

  task automatic run(input int ncyc);
    int  mw = 0;
    int  ml = 1;
    bit  req_m1 = 1'b0;
    bit  req_m2 = 1'b0;
    logic [7:0] last_d = 8'h00;
    bit  last_v = 1'b0;
    for (int j = 1; j <= ncyc; j++) begin
      @(negedge clk);
      if (j == 1) begin
        chk(vid_data == 8'h80, "R8 first cycle after release", vid_data, 8'h80);
      end else begin
        logic [7:0] e;
        string tag;
        bit act;
        act = (mw >= HB) && !v_of(ml);
        if (mw < 4 || (mw >= HB - 4 && mw < HB)) begin
          case (mw % 4)
            0: begin e = 8'hFF; tag = "R1 code lead byte"; end
            1: begin e = 8'h00; tag = "R2 code zero byte"; end
            2: begin e = 8'h00; tag = "R2 code zero byte"; end
            default: begin e = xy_of(f_of(ml), v_of(ml), mw < 4); tag = "R3 status byte"; end
          endcase
        end else if (act) begin
          e = last_v ? last_d : blank_of(mw);
          tag = "R6 active word";
        end else begin
          e = blank_of(mw);
          tag = "R4 blanking word";
        end
        chk(vid_data == e, tag, vid_data, e);
        chk(req_m2 == act, "R5 request timing", {7'd0, req_m2}, {7'd0, act});
        chk(line_start == (mw == 0), "R7 line_start", {7'd0, line_start}, {7'd0, mw == 0});
        chk(field_start == (mw == 0 && (ml == F0 || ml == F1)), "R7 field_start",
            {7'd0, field_start}, {7'd0, mw == 0 && (ml == F0 || ml == F1)});
        if (mw == 3 && ml == 1 && j > LW * NL)
          chk(vid_data == xy_of(1'b1, 1'b1, 1'b1), "R9 wrap to line 1", vid_data,
              xy_of(1'b1, 1'b1, 1'b1));
        mw++;
        if (mw == LW) begin
          mw = 0;
          ml = (ml == NL) ? 1 : ml + 1;
        end
      end
      // pixel source: answer requests, drop valid at times, raise valid unrequested
      if (req_m1) begin
        pix_valid = ($urandom % 6) != 0;
        pix_data  = 8'($urandom);
      end else begin
        pix_valid = ($urandom % 2) != 0;
        pix_data  = 8'($urandom);
      end
      last_d = pix_data;
      last_v = pix_valid && req_m1;
      req_m2 = req_m1;
      req_m1 = pix_req;
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1729);
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    run(LW * NL * 2 + 57);
    // directed: reset in the middle of a line, then restart at line 1
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    run(LW * NL * 3 + 10);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule